// File: doc/BRIEF.md
# Power-Mode Clock Selector

This block produces the core clock of a chip that moves between power modes. A two-bit mode input picks one of three sources: the reference clock at full rate, a slower clock made by dividing the reference by a programmable value, or no clock at all, with the output held low. All three sources meet in one gated multiplexer. Each source has its own enable. An enable is only switched while its source is low, so a mode change never produces a runt pulse.

A status clock at half the frequency of the selected clock is produced for system control logic. A lock indication from an external clock conditioner is synchronised and exported as a flag. While that indication is low, the selected clock is held low whatever the mode. The mode and lock inputs are asynchronous to the reference and pass through a synchroniser. The divide value is sampled by the divider itself.

Top module: `pwr_clk_sel`

## Requirements
- R1: With mode 2'b00 (full) and lock high, clk_o follows clk_i: high for half a reference period and low for the other half.
- R2: With mode 2'b01 (divided), lock high and divide value N of 1 or more, clk_o is high for N reference cycles and then low for N reference cycles.
- R3: A divide value of 0 behaves exactly as a value of 1.
- R4: A new divide value takes effect only at the next rising edge of the divided clock. The period in progress finishes with the old value.
- R5: With mode 2'b10 or 2'b11 (stop), clk_o is held low.
- R6: Source changes are glitch-free. At most one source enable is set at any time. The divided-clock enable changes only while the divided clock is low. The full-rate enable changes only while clk_i is low. During a switch, every high pulse on clk_o is a complete pulse of one source.
- R7: status_clk_o toggles on every rising edge of clk_o, so its period is two periods of clk_o.
- R8: lock_o equals lock_i delayed by SYNC_STAGES rising edges of clk_i (2 by default).
- R9: While lock_o is low, clk_o is held low in every mode, and no source is enabled.
- R10: While rst_ni is low, clk_o, status_clk_o and lock_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode: 00 full, 01 divided, 1x stop |
| div_val_i | input | DIV_W | Half-period of the divided clock in reference cycles (0 acts as 1) |
| lock_i | input | 1 | Lock indication from the clock conditioner |
| clk_o | output | 1 | Selected core clock |
| status_clk_o | output | 1 | Core clock divided by two |
| lock_o | output | 1 | Synchronised lock flag |

## Verification
The assertions check the switching rules on every edge. They confirm that at most one source is enabled, that the divided enable changes only while the divided clock is low, and that an enable rises only when the synchronised request names that source and lock is present. The scoreboard scenarios are needed for the waveform properties: the duty and period in full and divided modes, zero acting as one, the old half-periods finishing before a new divide value applies, the status clock period, the stop and lock-loss outputs, and the shape of the pulses across a live switch from full to divided.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;
  typedef enum logic [1:0] {
    SRC_FULL = 2'b00,
    SRC_DIV  = 2'b01,
    SRC_STOP = 2'b10
  } src_e;

  function automatic src_e decode_mode(input logic [1:0] m);
    unique case (m)
      2'b00:   return SRC_FULL;
      2'b01:   return SRC_DIV;
      default: return SRC_STOP;
    endcase
  endfunction
endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_val_i,
  output logic             div_clk_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] half_q, cnt_q, div_eff;
  logic             div_q;

  assign div_eff = (div_val_i == '0) ? ONE : div_val_i;

  // free-running; half-period reloads only at the low-to-high turn
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= ONE;
      cnt_q  <= '0;
      div_q  <= 1'b0;
    end else if (cnt_q == half_q - ONE) begin
      cnt_q <= '0;
      div_q <= ~div_q;
      if (!div_q) half_q <= div_eff;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign div_clk_o = div_q;
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pwr_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e req_i,
  input  logic div_clk_i,
  output logic en_full_o,
  output logic en_div_o
);
  logic en_full_q, en_div_q;

  // falling-edge domain: the full-rate source is low here; the divided
  // source is held stable between rising edges, so its level is known
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_full_q <= 1'b0;
      en_div_q  <= 1'b0;
    end else if (en_full_q && req_i != SRC_FULL) begin
      en_full_q <= 1'b0;
    end else if (en_div_q && req_i != SRC_DIV) begin
      if (!div_clk_i) en_div_q <= 1'b0;
    end else if (!en_full_q && !en_div_q) begin
      if (req_i == SRC_FULL)                 en_full_q <= 1'b1;
      else if (req_i == SRC_DIV && !div_clk_i) en_div_q <= 1'b1;
    end
  end

  assign en_full_o = en_full_q;
  assign en_div_o  = en_div_q;
endmodule

// File: rtl/pwr_clk_sel.sv
module pwr_clk_sel
  import pwr_clk_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic             lock_i,
  output logic             clk_o,
  output logic             status_clk_o,
  output logic             lock_o
);
  localparam int unsigned SW = 3;

  logic [SW-1:0] sync_d, sync_q;
  logic [1:0]    mode_s;
  logic          lock_s;
  src_e          req;
  logic          div_clk, en_full, en_div, sel_clk, stat_q;

  assign sync_d = {lock_i, mode_i};

  pcs_sync #(.STAGES(SYNC_STAGES), .W(SW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign mode_s = sync_q[1:0];
  assign lock_s = sync_q[2];
  assign req    = lock_s ? decode_mode(mode_s) : SRC_STOP;

  pcs_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_val_i(div_val_i),
    .div_clk_o(div_clk)
  );

  pcs_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .div_clk_i(div_clk),
    .en_full_o(en_full),
    .en_div_o (en_div)
  );

  // output multiplexer: gated sources, stop is the all-off case
  assign sel_clk = (clk_i & en_full) | (div_clk & en_div);

  always_ff @(posedge sel_clk or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= ~stat_q;
  end

  assign clk_o        = sel_clk;
  assign status_clk_o = stat_q;
  assign lock_o       = lock_s;
endmodule

// File: rtl/pwr_clk_sel_chk.sv
module pwr_clk_sel_chk
  import pwr_clk_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_full,
  input logic       en_div,
  input logic       div_clk,
  input logic       lock_o,
  input logic [1:0] req
);
  assert_one_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_full && en_div));

  assert_div_en_low_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ($rose(en_div) || $fell(en_div)) |-> !$past(div_clk));

  assert_full_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_full) |-> req == SRC_FULL);

  assert_div_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_div) |-> req == SRC_DIV);

  assert_lock_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(en_div) || $rose(en_full)) |-> lock_o);
endmodule

bind pwr_clk_sel pwr_clk_sel_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_full(en_full),
  .en_div (en_div),
  .div_clk(div_clk),
  .lock_o (lock_o),
  .req    (req)
);

// File: tb/pwr_clk_sel_tb_top.sv
`timescale 1ns/1ps
module pwr_clk_sel_tb_top;
  localparam int DIV_W = 8;
  localparam int NS    = 256;

  typedef int run_a[16];
  typedef bit lvl_a[16];
  typedef struct {
    int    hi;
    int    lo;
    bit    stopped;
    string tag;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       mode_i = 2'b00;
  logic [DIV_W-1:0] div_val_i = 8'd2;
  logic             lock_i = 1'b0;
  logic             clk_o, status_clk_o, lock_o;

  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  bit   busy = 1'b0;
  exp_t exp_q[$];

  logic [NS-1:0] co_v, st_v;
  int   co_ones;
  run_a co_r, st_r;
  lvl_a co_l, st_l;
  int   co_n, st_n;

  always #2.5 clk_i = ~clk_i;

  pwr_clk_sel #(.DIV_W(DIV_W), .SYNC_STAGES(2)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .div_val_i   (div_val_i),
    .lock_i      (lock_i),
    .clk_o       (clk_o),
    .status_clk_o(status_clk_o),
    .lock_o      (lock_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // samples a quarter period after each clock edge, two per reference cycle
  task automatic sample_window(input int n);
    co_ones = 0;
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0) @(posedge clk_i); else @(negedge clk_i);
      #1.25;
      co_v[i] = clk_o;
      st_v[i] = status_clk_o;
      if (clk_o) co_ones++;
    end
  endtask

  // complete runs only: the partial run before the first transition is dropped
  task automatic analyze(input logic [NS-1:0] v, input int n,
                         output run_a r, output lvl_a l, output int cnt);
    bit started = 1'b0;
    int cur = 1;
    cnt = 0;
    for (int k = 0; k < 16; k++) begin r[k] = 0; l[k] = 1'b0; end
    for (int i = 1; i < n; i++) begin
      if (v[i] != v[i-1]) begin
        if (started && cnt < 16) begin
          r[cnt] = cur;
          l[cnt] = v[i-1];
          cnt++;
        end
        started = 1'b1;
        cur = 1;
      end else begin
        cur++;
      end
    end
  endtask

  task automatic capture(input int n);
    sample_window(n);
    analyze(co_v, n, co_r, co_l, co_n);
    analyze(st_v, n, st_r, st_l, st_n);
  endtask

  // driver: apply a setting, let it settle, hand the expectation to the monitor
  task automatic drive(input logic [1:0] m, input int dv, input bit lk,
                       input int hi, input int lo, input bit stopped, input string tag);
    exp_t e;
    @(negedge clk_i);
    mode_i = m;
    div_val_i = DIV_W'(dv);
    lock_i = lk;
    repeat (40) @(posedge clk_i);
    e.hi = hi; e.lo = lo; e.stopped = stopped; e.tag = tag;
    exp_q.push_back(e);
    wait (exp_q.size() == 0 && !busy);
  endtask

  // monitor: measures the output and compares against the queued item
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() > 0);
      busy = 1'b1;
      e = exp_q.pop_front();
      capture(200);
      if (e.stopped) begin
        check({e.tag, " clk_o edges"}, co_n, 0);
        check({e.tag, " clk_o high samples"}, co_ones, 0);
      end else begin
        check({e.tag, " run count"}, int'(co_n >= 2), 1);
        check({e.tag, " high run"}, co_l[0] ? co_r[0] : co_r[1], e.hi);
        check({e.tag, " low run"},  co_l[0] ? co_r[1] : co_r[0], e.lo);
        check({e.tag, " R7 status run"}, st_r[0], e.hi + e.lo);
      end
      busy = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    int seen6;
    #11.25;
    check("R10 clk_o in reset", int'(clk_o), 0);
    check("R10 status_clk_o in reset", int'(status_clk_o), 0);
    check("R10 lock_o in reset", int'(lock_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);

    @(negedge clk_i);
    lock_i = 1'b1;
    @(posedge clk_i); #1.25;
    check("R8 lock_o after one edge", int'(lock_o), 0);
    @(posedge clk_i); #1.25;
    check("R8 lock_o after two edges", int'(lock_o), 1);

    drive(2'b00, 2, 1'b1, 1, 1, 1'b0, "R1 full rate");
    drive(2'b01, 4, 1'b1, 8, 8, 1'b0, "R2 divide by 4");
    drive(2'b01, 1, 1'b1, 2, 2, 1'b0, "R2 divide by 1");
    drive(2'b01, 0, 1'b1, 2, 2, 1'b0, "R3 divide value 0");
    drive(2'b10, 3, 1'b1, 0, 0, 1'b1, "R5 stop mode 10");
    drive(2'b11, 3, 1'b1, 0, 0, 1'b1, "R5 stop mode 11");
    drive(2'b00, 3, 1'b1, 1, 1, 1'b0, "R1 full after stop");
    drive(2'b00, 3, 1'b0, 0, 0, 1'b1, "R9 lock lost in full mode");
    check("R8 lock_o low after loss", int'(lock_o), 0);
    drive(2'b01, 3, 1'b0, 0, 0, 1'b1, "R9 lock lost in divided mode");
    drive(2'b00, 3, 1'b1, 1, 1, 1'b0, "R9 full after relock");
    check("R8 lock_o high after relock", int'(lock_o), 1);

    // live switch from full to divide by 3: only whole pulses of one source
    @(negedge clk_i);
    mode_i = 2'b01;
    div_val_i = 8'd3;
    capture(120);
    bad = 0;
    seen6 = 0;
    for (int k = 0; k < co_n; k++) begin
      if (co_l[k] && co_r[k] != 1 && co_r[k] != 6) bad++;
      if (co_l[k] && co_r[k] == 6) seen6++;
    end
    check("R6 malformed pulses during switch", bad, 0);
    check("R6 divided pulses reached", int'(seen6 > 0), 1);

    // divide value update mid-period
    repeat (20) @(posedge clk_i);
    @(posedge clk_o);
    #0.5;
    div_val_i = 8'd5;
    capture(60);
    check("R4 old low half-period completes", co_r[0], 6);
    check("R4 old run level is low", int'(co_l[0]), 0);
    check("R4 new high half-period", co_r[1], 10);
    check("R4 new low half-period", co_r[2], 10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule